// File: doc/BRIEF.md
# Block Floating-Point Normalizer

This block brings a small group of signed two's-complement words to one common scale. Words arrive one per cycle. Each input word is a little wider than the stored word: it carries a few guard bits above the word width, so a word that has grown past the word range during earlier arithmetic can still be presented. Once the block is complete, the normalizer picks one shift amount for every member. If any member spills into the guard bits, the whole group is moved right just far enough that the largest member fits again. Otherwise the group is moved left as far as the member with the fewest redundant sign bits allows. That uses the full word while every sign survives.

The shared shift is reported as a signed exponent for one cycle, positive for a left shift and negative for a right shift. The scaled words then stream out in the order they were loaded. A separate restore port takes a scaled word and its exponent, undoes the scaling with the opposite shift, and gives back a guard-extended word one cycle later. The loss of precision from the right shifts is its only source of error.

Top module: `bfp_normalizer`

## Requirements
- R1: After synchronous reset, exp_valid, out_valid and dn_out_valid are low.
- R2: For a nonnegative word that fits the word width, its left count is the number of left shifts that bring its highest 1 to bit WORD_W-2, just below the sign bit. A zero word counts WORD_W-1.
- R3: For a negative word that fits the word width, its left count is the number of left shifts that bring its highest 0 to bit WORD_W-2. Minus one counts WORD_W-1.
- R4: When no word overflows, exponent is the minimum left count over the block. Every out_data is then the word shifted left by that amount, and the exponent is nonnegative.
- R5: A word overflows when input bits [IN_W-1:WORD_W-1] are not all equal. If any word overflows, exponent is minus the largest right shift any word needs to fit WORD_W bits, and every word is shifted right arithmetically by that amount.
- R6: An all-zero block gives exponent 0 with blk_zero high during exp_valid. Any nonzero word gives blk_zero low.
- R7: exp_valid is high for exactly the cycle after the edge that takes the final word. The scaled words follow on out_valid in consecutive cycles, in load order, with out_last on the final one.
- R8: A block ends at the word that has in_last high, or at the N_WORDS-th word if in_last has not come by then. The number of streamed words equals the number loaded.
- R9: in_valid is ignored while the exponent is shown or words are streaming, and such words affect neither that block nor the next.
- R10: One cycle after dn_valid, dn_out_valid is high and dn_out holds dn_data sign-extended to IN_W bits and shifted opposite to dn_exp: arithmetically right by dn_exp when dn_exp ≥ 0, and left by -dn_exp when dn_exp < 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_data | input | IN_W | Signed input word with guard bits |
| in_last | input | 1 | Final word of the block |
| exp_valid | output | 1 | Exponent and zero flag valid |
| exponent | output | EXP_W | Signed shared shift, positive is left |
| blk_zero | output | 1 | Every word of the block is zero |
| out_valid | output | 1 | Scaled word present |
| out_data | output | WORD_W | Scaled signed word |
| out_last | output | 1 | Final scaled word |
| dn_valid | input | 1 | Restore request |
| dn_data | input | WORD_W | Scaled word to restore |
| dn_exp | input | EXP_W | Exponent recorded for that word |
| dn_out_valid | output | 1 | Restored word present |
| dn_out | output | IN_W | Restored signed word |

## Verification
Directed blocks separate the two count rules: a lone +2 and a lone -2 give left counts that differ by one, and a block holding both shows that the minimum wins. Further blocks cover all-zero, -1, the most negative word, and guard overflow needing one and two right shifts, so the zero, left and right cases are each seen on their own. Hundreds of pseudo-random blocks then mix magnitudes from a few bits up to the full guarded range, with short blocks, blocks ended by count, and stray in_valid pulses outside loading. A restore of every scaled word must return the original word, or for right shifts the original with its dropped low bits cleared.

// File: rtl/bfp_pkg.sv
`timescale 1ns/1ps
package bfp_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_EXP    = 2'd1,
        ST_STREAM = 2'd2
    } bfp_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bfp_word_scan.sv
`timescale 1ns/1ps
module bfp_word_scan #(
    parameter  int WORD_W  = 8,
    parameter  int GUARD_W = 2,
    localparam int IN_W    = WORD_W + GUARD_W,
    localparam int CW      = $clog2(WORD_W),
    localparam int RW      = $clog2(GUARD_W + 1)
) (
    input  logic [IN_W-1:0] word,
    output logic [CW-1:0]   lcount,
    output logic [RW-1:0]   rneed,
    output logic            nonzero
);

    // Redundant sign bits below the word's sign bit, and the right shift
    // that removes any spill into the guard bits.
    always_comb begin
        logic run;
        run    = 1'b1;
        lcount = '0;
        for (int i = WORD_W - 2; i >= 0; i--) begin
            if (run && (word[i] == word[WORD_W-1])) lcount = lcount + CW'(1);
            else                                    run    = 1'b0;
        end
        rneed = '0;
        for (int i = WORD_W - 1; i <= IN_W - 2; i++) begin
            if (word[i] != word[IN_W-1]) rneed = RW'(i - WORD_W + 2);
        end
        nonzero = |word;
    end

endmodule

// File: rtl/bfp_scaler.sv
`timescale 1ns/1ps
module bfp_scaler #(
    parameter int WORD_W  = 8,
    parameter int GUARD_W = 2,
    parameter int EXP_W   = 5,
    localparam int IN_W   = WORD_W + GUARD_W
) (
    input  logic signed [IN_W-1:0]   word,
    input  logic signed [EXP_W-1:0]  exp_in,
    output logic signed [WORD_W-1:0] scaled
);

    logic [EXP_W-1:0]       mag;
    logic signed [IN_W-1:0] rs;

    always_comb begin
        mag = exp_in[EXP_W-1] ? $unsigned(-exp_in) : $unsigned(exp_in);
        rs  = word >>> mag;
        if (exp_in[EXP_W-1]) scaled = rs[WORD_W-1:0];
        else                 scaled = word[WORD_W-1:0] << mag;
    end

endmodule

// File: rtl/bfp_restore.sv
`timescale 1ns/1ps
module bfp_restore #(
    parameter int WORD_W  = 8,
    parameter int GUARD_W = 2,
    parameter int EXP_W   = 5,
    localparam int IN_W   = WORD_W + GUARD_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dn_valid,
    input  logic signed [WORD_W-1:0] dn_data,
    input  logic signed [EXP_W-1:0]  dn_exp,
    output logic                     dn_out_valid,
    output logic signed [IN_W-1:0]   dn_out
);

    logic signed [IN_W-1:0] ext;
    logic [EXP_W-1:0]       mag;

    always_comb begin
        ext = {{GUARD_W{dn_data[WORD_W-1]}}, dn_data};
        mag = dn_exp[EXP_W-1] ? $unsigned(-dn_exp) : $unsigned(dn_exp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_out_valid <= 1'b0;
            dn_out       <= '0;
        end else begin
            dn_out_valid <= dn_valid;
            if (dn_valid) dn_out <= dn_exp[EXP_W-1] ? (ext << mag) : (ext >>> mag);
        end
    end

endmodule

// File: rtl/bfp_normalizer.sv
`timescale 1ns/1ps
module bfp_normalizer
    import bfp_pkg::*;
#(
    parameter  int N_WORDS = 4,
    parameter  int WORD_W  = 8,
    parameter  int GUARD_W = 2,
    localparam int IN_W    = WORD_W + GUARD_W,
    localparam int CW      = $clog2(WORD_W),
    localparam int RW      = $clog2(GUARD_W + 1),
    localparam int EXP_W   = imax(CW, RW) + 2,
    localparam int IDX_W   = $clog2(N_WORDS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_data,
    input  logic                     in_last,
    output logic                     exp_valid,
    output logic signed [EXP_W-1:0]  exponent,
    output logic                     blk_zero,
    output logic                     out_valid,
    output logic signed [WORD_W-1:0] out_data,
    output logic                     out_last,
    input  logic                     dn_valid,
    input  logic signed [WORD_W-1:0] dn_data,
    input  logic signed [EXP_W-1:0]  dn_exp,
    output logic                     dn_out_valid,
    output logic signed [IN_W-1:0]   dn_out
);

    bfp_state_e             st;
    logic [IDX_W-1:0]       idx;
    logic [IDX_W-1:0]       len;
    logic [CW-1:0]          min_l;
    logic [RW-1:0]          max_r;
    logic                   any_nz;
    logic signed [IN_W-1:0] mem [N_WORDS];

    logic [CW-1:0] w_lcount;
    logic [RW-1:0] w_rneed;
    logic          w_nonzero;
    logic          first_w;
    logic          end_blk;

    bfp_word_scan #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_scan (
        .word    (in_data),
        .lcount  (w_lcount),
        .rneed   (w_rneed),
        .nonzero (w_nonzero)
    );

    assign first_w = (idx == '0);
    assign end_blk = in_last || (idx == IDX_W'(N_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_LOAD;
            idx    <= '0;
            len    <= '0;
            min_l  <= '0;
            max_r  <= '0;
            any_nz <= 1'b0;
        end else begin
            unique case (st)
                ST_LOAD: if (in_valid) begin
                    mem[idx] <= in_data;
                    min_l    <= (first_w || (w_lcount < min_l)) ? w_lcount : min_l;
                    max_r    <= (first_w || (w_rneed > max_r))  ? w_rneed  : max_r;
                    any_nz   <= first_w ? w_nonzero : (any_nz | w_nonzero);
                    if (end_blk) begin
                        len <= idx;
                        idx <= '0;
                        st  <= ST_EXP;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_EXP: st <= ST_STREAM;
                ST_STREAM: begin
                    if (idx == len) begin
                        idx <= '0;
                        st  <= ST_LOAD;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: st <= ST_LOAD;
            endcase
        end
    end

    always_comb begin
        if (max_r != '0)  exponent = -$signed(EXP_W'(max_r));
        else if (!any_nz) exponent = '0;
        else              exponent = $signed(EXP_W'(min_l));
    end

    assign blk_zero  = !any_nz;
    assign exp_valid = (st == ST_EXP);
    assign out_valid = (st == ST_STREAM);
    assign out_last  = (st == ST_STREAM) && (idx == len);

    bfp_scaler #(.WORD_W(WORD_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) u_scale (
        .word   (mem[idx]),
        .exp_in (exponent),
        .scaled (out_data)
    );

    bfp_restore #(.WORD_W(WORD_W), .GUARD_W(GUARD_W), .EXP_W(EXP_W)) u_rest (
        .clk          (clk),
        .rst          (rst),
        .dn_valid     (dn_valid),
        .dn_data      (dn_data),
        .dn_exp       (dn_exp),
        .dn_out_valid (dn_out_valid),
        .dn_out       (dn_out)
    );

endmodule

// File: rtl/bfp_normalizer_chk.sv
`timescale 1ns/1ps
module bfp_normalizer_chk #(
    parameter int WORD_W  = 8,
    parameter int GUARD_W = 2,
    parameter int EXP_W   = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    exp_valid,
    input logic signed [EXP_W-1:0] exponent,
    input logic                    blk_zero,
    input logic                    out_valid,
    input logic                    out_last,
    input logic                    dn_valid,
    input logic                    dn_out_valid
);

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
        exp_valid |-> (int'(exponent) >= -GUARD_W) && (int'(exponent) <= WORD_W - 1)); // R4
    AST_ZERO_EXP: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && blk_zero) |-> (exponent == '0)); // R6
    AST_EXP_THEN_STREAM: assert property (@(posedge clk) disable iff (rst)
        exp_valid |=> (out_valid && !exp_valid)); // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(exp_valid && out_valid)); // R7
    AST_STREAM_CONT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid); // R7
    AST_STREAM_END: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (!out_valid && !exp_valid)); // R8
    AST_LAST_QUAL: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R7
    AST_EXP_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(exp_valid || out_valid)) |-> $stable(exponent)); // R4
    AST_RESTORE_LAT: assert property (@(posedge clk) disable iff (rst)
        dn_valid |=> dn_out_valid); // R10
    AST_RESTORE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dn_valid |=> !dn_out_valid); // R10

endmodule

bind bfp_normalizer bfp_normalizer_chk #(
    .WORD_W (WORD_W),
    .GUARD_W(GUARD_W),
    .EXP_W  (EXP_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .exp_valid    (exp_valid),
    .exponent     (exponent),
    .blk_zero     (blk_zero),
    .out_valid    (out_valid),
    .out_last     (out_last),
    .dn_valid     (dn_valid),
    .dn_out_valid (dn_out_valid)
);

// File: tb/sim_bfp_normalizer.sv
`timescale 1ns/1ps
module sim_bfp_normalizer;

    localparam int NW = 4;
    localparam int WW = 8;
    localparam int GW = 2;
    localparam int IW = WW + GW;
    localparam int EW = 5;
    localparam int WMIN = -(1 << (WW - 1));
    localparam int WMAX = (1 << (WW - 1)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [IW-1:0] in_data = '0;
    logic in_last = 1'b0;
    logic exp_valid;
    logic signed [EW-1:0] exponent;
    logic blk_zero;
    logic out_valid;
    logic signed [WW-1:0] out_data;
    logic out_last;
    logic dn_valid = 1'b0;
    logic signed [WW-1:0] dn_data = '0;
    logic signed [EW-1:0] dn_exp = '0;
    logic dn_out_valid;
    logic signed [IW-1:0] dn_out;

    int n_cmp = 0;
    int n_bad = 0;
    int seed  = 32'h1234_5678;

    always #2.5 clk = ~clk;

    bfp_normalizer #(.N_WORDS(NW), .WORD_W(WW), .GUARD_W(GW)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .exp_valid(exp_valid), .exponent(exponent), .blk_zero(blk_zero),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .dn_valid(dn_valid), .dn_data(dn_data), .dn_exp(dn_exp),
        .dn_out_valid(dn_out_valid), .dn_out(dn_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int m_left(input int v);
        int k = 0;
        while (k < WW - 1 && (v * (1 << (k + 1))) >= WMIN && (v * (1 << (k + 1))) <= WMAX) k++;
        return k;
    endfunction

    function automatic int m_right(input int v);
        int r = 0;
        while ((v >>> r) < WMIN || (v >>> r) > WMAX) r++;
        return r;
    endfunction

    function automatic int nextrand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h00FF_FFFF;
    endfunction

    task automatic run_block(input int vals[NW], input int n, input bit use_last,
                             input bit junk, input string etag);
        int e;
        int rmax = 0;
        int lmin = WW - 1;
        bit nz = 1'b0;
        int sc [NW];
        for (int i = 0; i < n; i++) begin
            if (m_right(vals[i]) > rmax) rmax = m_right(vals[i]);
            if (m_left(vals[i]) < lmin) lmin = m_left(vals[i]);
            if (vals[i] != 0) nz = 1'b1;
        end
        e = (rmax > 0) ? -rmax : (nz ? lmin : 0);
        for (int i = 0; i < n; i++)
            sc[i] = (e >= 0) ? vals[i] * (1 << e) : (vals[i] >>> (-e));

        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = IW'(vals[i]);
            in_last  = use_last && (i == n - 1);
        end
        @(negedge clk);
        in_valid = junk;
        in_data  = IW'(-511);
        in_last  = junk;
        check("R7", "exp_valid", int'(exp_valid), 1);
        check(etag, "exponent", int'(exponent), e);
        check("R6", "blk_zero", int'(blk_zero), int'(!nz));
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_data = IW'(i * 37 + 100);
            check(junk ? "R9" : "R7", "out_valid", int'(out_valid), 1);
            check(junk ? "R9" : "R7", "out_data", int'(out_data), sc[i]);
            check("R8", "out_last", int'(out_last), int'(i == n - 1));
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check("R8", "out_valid after last", int'(out_valid), 0);
        for (int i = 0; i < n; i++) begin
            dn_valid = 1'b1;
            dn_data  = WW'(sc[i]);
            dn_exp   = EW'(e);
            @(negedge clk);
            dn_valid = 1'b0;
            check("R10", "dn_out_valid", int'(dn_out_valid), 1);
            check("R10", "dn_out", int'(dn_out),
                  (e >= 0) ? vals[i] : ((vals[i] >>> (-e)) * (1 << (-e))));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "exp_valid", int'(exp_valid), 0);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "dn_out_valid", int'(dn_out_valid), 0);

        run_block('{2, 0, 0, 0}, 4, 1'b1, 1'b0, "R2");      // +2 -> 5
        run_block('{-2, 0, 0, 0}, 4, 1'b1, 1'b0, "R3");     // -2 -> 6
        run_block('{2, -2, 0, 0}, 4, 1'b1, 1'b0, "R4");     // min -> 5
        run_block('{-1, 0, 0, 0}, 4, 1'b1, 1'b0, "R3");     // -1 -> 7
        run_block('{-128, 3, 0, 1}, 4, 1'b1, 1'b0, "R4");   // -> 0
        run_block('{0, 0, 0, 0}, 4, 1'b1, 1'b0, "R6");      // zero block
        run_block('{200, -3, 5, 0}, 4, 1'b1, 1'b0, "R5");   // -> -1
        run_block('{-512, 1, -7, 0}, 4, 1'b1, 1'b0, "R5");  // -> -2
        run_block('{511, -256, 0, 2}, 4, 1'b1, 1'b1, "R5"); // -> -2, R9 junk
        run_block('{12, -5, 0, 0}, 2, 1'b1, 1'b0, "R8");    // short block
        run_block('{3, 9, -20, 1}, 4, 1'b0, 1'b0, "R8");    // ends by count
        run_block('{1, 1, 1, 1}, 4, 1'b1, 1'b1, "R9");      // after junk

        for (int b = 0; b < 500; b++) begin
            int vals [NW];
            int s = nextrand() % 10;
            int n = 1 + (nextrand() % NW);
            for (int i = 0; i < NW; i++) begin
                int span = 1 << (s + 1);
                vals[i] = ((nextrand() % 5) == 0) ? 0 : ((nextrand() % span) - (span / 2));
            end
            run_block(vals, n, (n < NW) || (nextrand() % 2 == 0), (b % 2) == 1, "R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule